// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that lets an external host read and write a small bank of 8-bit registers inside the chip. SCL and SDA are sampled by the system clock through a synchronizer. Bus events are detected on the synchronized samples. A state machine decodes the transaction and drives SDA only by pulling it low through an output enable. Register storage sits outside the block and is reached through a simple strobe port. Writes use a strobe with an index and a byte. Reads present an index and take the byte back in the same cycle.

A host selects the target with a 7-bit address. The upper six bits are fixed at 001110, and the lowest bit follows the `addr_strap` input. In write direction the first byte is a pointer byte: its bit 7 turns on pointer auto-increment and bits 6..0 give the register index. Each following byte is written to the register the pointer names. To read, the host sets the pointer this way, issues a repeated START and addresses the target again with direction 1. The target then streams bytes for as long as the host acknowledges them.

The state machine has ten states:

| State | Role |
|---|---|
| IDLE | Waits for a START. |
| ADDR | Shifts in the address byte. |
| ADDR_ACK | Drives the acknowledge for the address. On a read it also fetches the first data byte. |
| SUB | Receives the pointer byte. |
| SUB_ACK | Acknowledges the pointer byte. |
| WDATA | Receives a write data byte. |
| WDATA_ACK | Acknowledges a write data byte. |
| RDATA | Shifts a read byte out. |
| RACK | Samples the host's acknowledge and, on ACK, fetches the next byte. |
| IGNORE | Stays silent until the next START or STOP. |

Transitions, each taken on a falling SCL edge unless noted:
- From ADDR, the 8th bit leads to ADDR_ACK when the address matches, or to IGNORE when it does not.
- From ADDR_ACK, the next state is RDATA for direction 1 and SUB for direction 0.
- SUB goes to SUB_ACK, and SUB_ACK goes to WDATA.
- WDATA goes to WDATA_ACK, and WDATA_ACK returns to WDATA.
- RDATA goes to RACK after the 8th bit.
- RACK goes to RDATA when the host sent ACK, and to IGNORE when it sent NACK.
- A START sends any state to ADDR, and a STOP sends any state to IDLE; these two take effect on their own cycle, not on an SCL edge.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and neither `reg_wr_en` nor `reg_rd_en` is asserted until a transaction addresses the target.
- R2: The target acknowledges an address byte whose upper seven bits equal {001110, `addr_strap`} by pulling SDA low through the ninth SCL clock. The eighth bit is the direction, where 1 means read.
- R3: After an address byte that does not match, the target never pulls SDA and issues no register strobe until the next START.
- R4: In write direction, the first byte after the address is the pointer byte (bit 7 = auto-increment, bits 6..0 = index). Every later byte is acknowledged and written to the pointed register with a one-cycle `reg_wr_en` pulse.
- R5: With auto-increment set, the index advances by one after each data byte, in both directions, and wraps from 127 to 0.
- R6: With auto-increment clear, every byte of a burst, written or read, uses the same register.
- R7: After a repeated START with direction 1, the target returns the register at the pointer, most significant bit first. The byte is fetched during the acknowledge clock of the address.
- R8: During a read, a host ACK makes the target send the next byte. A host NACK followed by STOP ends the burst, with SDA released.
- R9: An index at or above NUM_REGS (16 by default) reads as 00h, and a write to it produces no `reg_wr_en` pulse.
- R10: A START seen in any state, including in the middle of a byte, restarts address reception. A STOP returns the target to idle.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| addr_strap | input | 1 | Lowest bit of the target address |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_idx | output | 7 | Register index for the write |
| reg_wr_data | output | 8 | Write data byte |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_rd_idx | output | 7 | Register index for the read |
| reg_rd_data | input | 8 | Read data, valid in the same cycle as the index |

## Verification
An SCL edge reaches the state machine three system clocks after it appears on the pins: two synchronizer flops, then the edge register. `sda_oe` therefore moves about three clocks after SCL falls, and `reg_wr_en` fires about three clocks after the eighth rising edge of a data byte. The bench holds each SCL phase for ten clocks. It changes SDA five clocks into the low phase and samples SDA five clocks into the high phase, well after every due result. It compares register contents and strobe counts only after the STOP of each transaction. A monitor on every clock checks that `sda_oe` never moves while SCL is high.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // bus lines idle high, so the chain resets to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_detect.sv
module i2c_bus_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // SDA moving while SCL stays high marks a bus condition
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR_HI = 6'b001110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_strap,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_pull,
    output logic              wr_stb,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              rd_stb,
    output logic [IDX_W-1:0]  rd_idx,
    output tgt_state_e        state_o
);
    tgt_state_e        state_q;
    tgt_state_e        state_nx;
    logic [3:0]        bitcnt_q;
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] tx_q;
    logic [IDX_W-1:0]  ptr_q;
    logic              auto_q;
    logic              rw_q;
    logic              mack_q;

    logic [BYTE_W-1:0] rx_full;
    logic              rx_state;
    logic              last_rx_rise;
    logic              byte_in;
    logic              addr_hit;

    assign rx_full      = {rx_q[BYTE_W-2:0], sda_s};
    assign rx_state     = (state_q == ST_ADDR) || (state_q == ST_SUB) || (state_q == ST_WDATA);
    assign last_rx_rise = scl_rise && (bitcnt_q == 4'd7);
    assign byte_in      = scl_fall && (bitcnt_q == 4'd8);
    assign addr_hit     = (rx_q[BYTE_W-1:1] == {DEV_ADDR_HI, addr_strap});

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:      state_nx = ST_IDLE;
            ST_ADDR:      if (byte_in) state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
            ST_ADDR_ACK:  if (scl_fall) state_nx = rw_q ? ST_RDATA : ST_SUB;
            ST_SUB:       if (byte_in) state_nx = ST_SUB_ACK;
            ST_SUB_ACK:   if (scl_fall) state_nx = ST_WDATA;
            ST_WDATA:     if (byte_in) state_nx = ST_WDATA_ACK;
            ST_WDATA_ACK: if (scl_fall) state_nx = ST_WDATA;
            ST_RDATA:     if (scl_fall && bitcnt_q == 4'd7) state_nx = ST_RACK;
            ST_RACK:      if (scl_fall) state_nx = mack_q ? ST_RDATA : ST_IGNORE;
            ST_IGNORE:    state_nx = ST_IGNORE;
            default:      state_nx = ST_IDLE;
        endcase
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // datapath: bit counter, shifters, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            rx_q     <= '0;
            tx_q     <= '0;
            ptr_q    <= '0;
            auto_q   <= 1'b0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
        end else begin
            if (start_det || (state_nx != state_q)) begin
                bitcnt_q <= '0;
            end else if ((scl_rise && rx_state) || (scl_fall && state_q == ST_RDATA)) begin
                bitcnt_q <= bitcnt_q + 4'd1;
            end

            if (scl_rise && rx_state) begin
                rx_q <= rx_full;
            end

            if (state_q == ST_ADDR && state_nx == ST_ADDR_ACK) begin
                rw_q <= rx_q[0];
            end

            if (state_q == ST_RACK && scl_rise) begin
                mack_q <= ~sda_s;
            end

            if (state_q == ST_SUB && last_rx_rise) begin
                ptr_q  <= rx_full[IDX_W-1:0];
                auto_q <= rx_full[BYTE_W-1];
            end else if (auto_q && (wr_stb || (state_q == ST_RDATA && state_nx == ST_RACK))) begin
                ptr_q <= ptr_q + 7'd1;
            end

            if (rd_stb) begin
                tx_q <= rd_byte;
            end else if (state_q == ST_RDATA && scl_fall) begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        sda_pull = 1'b0;
        wr_stb   = 1'b0;
        rd_stb   = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK: begin
                sda_pull = 1'b1;
                rd_stb   = scl_rise && rw_q;
            end
            ST_SUB_ACK, ST_WDATA_ACK: sda_pull = 1'b1;
            ST_WDATA:    wr_stb   = last_rx_rise;
            ST_RDATA:    sda_pull = ~tx_q[BYTE_W-1];
            ST_RACK:     rd_stb   = scl_rise && ~sda_s;
            default: begin
                sda_pull = 1'b0;
            end
        endcase
        wr_idx  = ptr_q;
        wr_byte = rx_full;
        rd_idx  = ptr_q;
        state_o = state_q;
    end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
    parameter logic [5:0] DEV_ADDR_HI = 6'b001110,
    parameter int         NUM_REGS    = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             scl_i,
    input  logic                             sda_i,
    output logic                             sda_oe,
    input  logic                             addr_strap,
    output logic                             reg_wr_en,
    output logic [i2c_tgt_pkg::IDX_W-1:0]    reg_wr_idx,
    output logic [i2c_tgt_pkg::BYTE_W-1:0]   reg_wr_data,
    output logic                             reg_rd_en,
    output logic [i2c_tgt_pkg::IDX_W-1:0]    reg_rd_idx,
    input  logic [i2c_tgt_pkg::BYTE_W-1:0]   reg_rd_data
);
    import i2c_tgt_pkg::*;

    localparam logic [IDX_W:0] REG_LIMIT = (IDX_W+1)'(NUM_REGS);

    logic [1:0]        line_s;
    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              fsm_wr;
    logic              fsm_rd;
    logic [IDX_W-1:0]  fsm_wr_idx;
    logic [IDX_W-1:0]  fsm_rd_idx;
    logic [BYTE_W-1:0] fsm_rd_byte;
    logic              wr_ok;
    logic              rd_ok;
    tgt_state_e        fsm_state;

    i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2c_bus_detect u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(.DEV_ADDR_HI(DEV_ADDR_HI)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_s      (sda_s),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .addr_strap (addr_strap),
        .rd_byte    (fsm_rd_byte),
        .sda_pull   (sda_oe),
        .wr_stb     (fsm_wr),
        .wr_idx     (fsm_wr_idx),
        .wr_byte    (reg_wr_data),
        .rd_stb     (fsm_rd),
        .rd_idx     (fsm_rd_idx),
        .state_o    (fsm_state)
    );

    // indices beyond the implemented bank read as zero and drop writes
    assign wr_ok       = ({1'b0, fsm_wr_idx} < REG_LIMIT);
    assign rd_ok       = ({1'b0, fsm_rd_idx} < REG_LIMIT);
    assign reg_wr_en   = fsm_wr & wr_ok;
    assign reg_wr_idx  = fsm_wr_idx;
    assign reg_rd_en   = fsm_rd & rd_ok;
    assign reg_rd_idx  = fsm_rd_idx;
    assign fsm_rd_byte = rd_ok ? reg_rd_data : '0;
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       reg_wr_en,
    input logic       reg_rd_en,
    input logic       start_det,
    input logic       stop_det,
    input tgt_state_e state
);
    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    p_start_to_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR));

    p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    p_fetch_scl_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |-> scl_s);

    p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!reg_wr_en && !reg_rd_en && !sda_oe));
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .scl_s     (scl_s),
    .sda_oe    (sda_oe),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .start_det (start_det),
    .stop_det  (stop_det),
    .state     (fsm_state)
);

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
    localparam int NREG = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       strap = 1'b0;
    logic       sda_bus;
    logic       sda_oe;
    logic       wr_en;
    logic [6:0] wr_idx;
    logic [7:0] wr_data;
    logic       rd_en;
    logic [6:0] rd_idx;
    logic [7:0] rd_data;

    logic [7:0] rf [NREG];
    logic [7:0] exp_rf [NREG];
    int         wr_cnt = 0;
    int         n_tests = 0;
    int         n_fail = 0;
    int         oe_glitch = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_reg_target dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_oe      (sda_oe),
        .addr_strap  (strap),
        .reg_wr_en   (wr_en),
        .reg_wr_idx  (wr_idx),
        .reg_wr_data (wr_data),
        .reg_rd_en   (rd_en),
        .reg_rd_idx  (rd_idx),
        .reg_rd_data (rd_data)
    );

    // external register bank model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf[i] <= 8'h00;
        end else if (wr_en) begin
            rf[wr_idx[3:0]] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end
    assign rd_data = rf[rd_idx[3:0]];

    // R11 monitor: output enable must not move while SCL is high
    logic oe_prev = 1'b0;
    always @(posedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl_m) oe_glitch <= oe_glitch + 1;
        oe_prev <= sda_oe;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wt(5);
        scl_m = 1'b1; wt(10);
        sda_m = 1'b0; wt(10);
        scl_m = 1'b0; wt(5);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wt(5);
        scl_m = 1'b1; wt(10);
        sda_m = 1'b1; wt(10);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wt(5);
        scl_m = 1'b1; wt(10);
        scl_m = 1'b0; wt(5);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wt(5);
        scl_m = 1'b1; wt(5);
        b = sda_bus; wt(5);
        scl_m = 1'b0; wt(5);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~mack);
    endtask

    function automatic logic [7:0] abyte(input logic lsb, input logic rw);
        return {6'b001110, lsb, rw};
    endfunction

    task automatic do_write(input logic lsb, input logic [7:0] sub, input int n,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                            input string req);
        logic       ack;
        logic [7:0] d [3];
        logic [6:0] idx;
        int         start_cnt;
        int         exp_inc;
        d[0] = d0; d[1] = d1; d[2] = d2;
        start_cnt = wr_cnt;
        exp_inc = 0;
        idx = sub[6:0];
        i2c_start();
        send_byte(abyte(lsb, 1'b0), ack);
        check({"R2 address ack / ", req}, ack, 1);
        send_byte(sub, ack);
        check({"R4 pointer ack / ", req}, ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], ack);
            check({"R4 data ack / ", req}, ack, 1);
            if (idx < NREG) begin
                exp_rf[idx[3:0]] = d[k];
                exp_inc++;
            end
            if (sub[7]) idx = idx + 7'd1;
        end
        i2c_stop();
        check({"R9 strobe count / ", req}, wr_cnt - start_cnt, exp_inc);
        for (int i = 0; i < NREG; i++) check({"R4 bank / ", req}, rf[i], exp_rf[i]);
    endtask

    task automatic do_read(input logic lsb, input logic [7:0] sub, input int n,
                           input string req, output logic [7:0] first);
        logic       ack;
        logic [7:0] v;
        logic [6:0] idx;
        logic [7:0] e;
        idx = sub[6:0];
        first = 8'h00;
        i2c_start();
        send_byte(abyte(lsb, 1'b0), ack);
        check({"R2 address ack / ", req}, ack, 1);
        send_byte(sub, ack);
        check({"R4 pointer ack / ", req}, ack, 1);
        i2c_start();
        send_byte(abyte(lsb, 1'b1), ack);
        check({"R7 read address ack / ", req}, ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(v, k < n - 1);
            e = (idx < NREG) ? exp_rf[idx[3:0]] : 8'h00;
            check({"R7 read data / ", req}, v, e);
            if (k == 0) first = v;
            if (sub[7]) idx = idx + 7'd1;
        end
        i2c_stop();
        wt(5);
        check({"R8 released after stop / ", req}, sda_oe, 0);
    endtask

    // sub-address, write byte, expected read-back
    localparam logic [23:0] VEC [6] = '{
        {8'h02, 8'hA5, 8'hA5},
        {8'h0F, 8'h3C, 8'h3C},
        {8'h85, 8'h5A, 8'h5A},
        {8'h00, 8'hFF, 8'hFF},
        {8'h20, 8'h77, 8'h00},
        {8'h7F, 8'h12, 8'h00}
    };

    initial begin
        repeat (500000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] got;
        int         cnt0;
        for (int i = 0; i < NREG; i++) exp_rf[i] = 8'h00;
        wt(4);
        check("R1 oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        wt(20);
        check("R1 oe after reset", sda_oe, 0);
        check("R1 no write strobe", wr_cnt, 0);
        check("R1 no read strobe", rd_en, 0);

        // vector table: single write then single read back (R4, R9)
        for (int v = 0; v < 6; v++) begin
            do_write(1'b0, VEC[v][23:16], 1, VEC[v][15:8], 8'h00, 8'h00, "R4 vector");
            do_read(1'b0, VEC[v][23:16], 1, "R7 vector", got);
            check("R4/R9 vector read-back", got, VEC[v][7:0]);
        end

        // R5: auto-increment burst write across the 127 -> 0 wrap
        do_write(1'b0, 8'hFF, 3, 8'hE1, 8'hE2, 8'hE3, "R5 wrap burst");
        check("R5 index 0 after wrap", rf[0], 8'hE2);
        check("R5 index 1 after wrap", rf[1], 8'hE3);

        // R6: no auto-increment, burst lands on one register
        do_write(1'b0, 8'h06, 3, 8'h11, 8'h22, 8'h33, "R6 fixed burst");
        check("R6 last byte kept", rf[6], 8'h33);
        check("R6 neighbour untouched", rf[7], 8'h00);
        do_read(1'b0, 8'h06, 3, "R6 fixed read", got);

        // R8: auto-increment burst read, NACK on last
        do_write(1'b0, 8'h83, 3, 8'h31, 8'h32, 8'h33, "R8 fill");
        do_read(1'b0, 8'h83, 3, "R8 burst read", got);
        check("R8 first byte", got, 8'h31);

        // R9: burst read running past the bank end
        do_read(1'b0, 8'h8E, 3, "R9 read past end", got);

        // R3: wrong address, then bytes that must be ignored
        cnt0 = wr_cnt;
        i2c_start();
        send_byte(abyte(1'b1, 1'b0), ack);
        check("R3 no ack on mismatch", ack, 0);
        send_byte(8'h01, ack);
        check("R3 no ack on later byte", ack, 0);
        send_byte(8'h99, ack);
        check("R3 no ack on data", ack, 0);
        i2c_stop();
        check("R3 no strobe", wr_cnt - cnt0, 0);
        do_read(1'b0, 8'h01, 1, "R3 reg 1 kept", got);

        // R2: strap moves the address
        strap = 1'b1;
        wt(10);
        do_write(1'b1, 8'h09, 1, 8'h66, 8'h00, 8'h00, "R2 strap high");
        do_read(1'b1, 8'h09, 1, "R2 strap high read", got);
        check("R2 strap read value", got, 8'h66);
        i2c_start();
        send_byte(abyte(1'b0, 1'b0), ack);
        check("R2 old address refused", ack, 0);
        i2c_stop();
        strap = 1'b0;
        wt(10);

        // R10: START in the middle of a byte restarts address reception
        i2c_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        do_write(1'b0, 8'h0A, 1, 8'hC7, 8'h00, 8'h00, "R10 restart mid-byte");
        check("R10 write after restart", rf[10], 8'hC7);

        check("R11 oe never moved with SCL high", oe_glitch, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule